// File: doc/BRIEF.md
# Indirect Interrupt Redirection Register File

This block holds the routing configuration for a set of interrupt inputs and exposes it to software through an indirect window of two 32-bit locations. Byte offset 0 holds an index, and byte offset 16 is a data window onto the register that the index names. Behind the window there are four kinds of register. An identifier register and an arbitration identifier register each keep a 4-bit value in bits 27:24. A version register can only be read. A table holds one 64-bit redirection entry per interrupt input, and each entry is reached as two 32-bit halves at consecutive indices.

The decoded fields of every entry leave the block on flat output buses, so that the routing logic next to it can read them without using the window. These fields are mask, vector, delivery mode, destination mode, polarity, trigger and destination. Reads return data one cycle after the read strobe. An access to any byte offset other than 0 or 16 is refused and raises a one-cycle error pulse.

Top module: `irq_route_regs`

## Requirements
- R1: A write at byte offset 0 stores the low 8 bits of the data as the register index. A read at offset 0 returns that index in bits 7:0, with bits 31:8 zero. The index resets to 0.
- R2: A read or write strobe at any byte offset other than 0 or 16 raises `err` for exactly the one cycle after the strobe and changes no state. Such a read returns zero on `rdata`.
- R3: `rdata` takes the read value on the clock edge of the read strobe. It holds that value until the next read strobe.
- R4: Index 0x00 is the identifier. A write keeps data bits 27:24, and a read returns them in bits 27:24 with every other bit zero. It resets to the `ID_INIT` parameter.
- R5: Index 0x01 is read-only. It reads as ((N_ENT-1) << 16) | VERSION, which is 0x00170011 with the default parameters, and a write to it has no effect.
- R6: Index 0x02 is the arbitration identifier. It uses the same bit 27:24 layout as the identifier, resets to `ID_INIT`, and is written independently of index 0x00.
- R7: Entry n has its low half at index 0x10+2n and its high half at 0x10+2n+1. The low half holds vector[7:0], delivery mode[10:8], destination mode[11], polarity[13], trigger[15] and mask[16]. The high half holds the destination in bits 31:24. These fields appear on the per-entry output buses one cycle after the write.
- R8: A write to a low half clears every bit outside the mask 0x0001AFFF. A write to a high half clears every bit outside the mask 0xFF000000.
- R9: After reset every entry reads 0x00010000 (low half) and 0x00000000 (high half), so every input starts masked.
- R10: A read of an index that is not defined returns zero, and a write to such an index changes no register. Undefined indices are 0x03 to 0x0F and 0x10+2*N_ENT and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe, one 32-bit write per cycle |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid the cycle after `rd_en` |
| err | output | 1 | One-cycle pulse after an access to an illegal offset |
| ent_mask | output | N_ENT | Mask bit of each entry |
| ent_vector | output | 8*N_ENT | Vector of each entry, entry n at [8n+7:8n] |
| ent_dmode | output | 3*N_ENT | Delivery mode of each entry |
| ent_dstmode | output | N_ENT | Destination mode of each entry |
| ent_pol | output | N_ENT | Polarity of each entry |
| ent_trig | output | N_ENT | Trigger mode of each entry |
| ent_dest | output | 8*N_ENT | Destination of each entry |

## Verification
A decoding fault in the index shows at the ports on the next data-window read. A write that lands in the wrong table half shows the same way, and it also shows on the field buses of the wrong entry one cycle after the write. A wrong reserved-bit mask shows as extra set bits in the read-back value. A fault in the offset check shows as a missing or misplaced `err` pulse one cycle after the strobe. The tests write all-ones patterns and read them back, and they check the edge indices: the last entry's high half and the first index past the table. These catch corruption that would otherwise go unseen until an interrupt is misrouted.

// File: rtl/irq_regs_pkg.sv
package irq_regs_pkg;
   localparam int DATA_W      = 32;
   localparam int SEL_OFS     = 0;
   localparam int WIN_OFS     = 16;
   localparam int IDX_ID      = 0;
   localparam int IDX_VER     = 1;
   localparam int IDX_ARB     = 2;
   localparam int IDX_TAB     = 16;
   localparam logic [31:0] LO_KEEP = 32'h0001_AFFF;
   localparam logic [31:0] HI_KEEP = 32'hFF00_0000;
   localparam int MASK_BIT    = 16;
   localparam int ID_LSB      = 24;

   typedef struct packed {
      logic is_id;
      logic is_ver;
      logic is_arb;
      logic is_tab;
      logic tab_hi;
   } reg_kind_t;
endpackage

// File: rtl/irq_sel_decode.sv
module irq_sel_decode
   import irq_regs_pkg::*;
#(
   parameter int SEL_W = 8,
   parameter int N_ENT = 24,
   localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
   input  logic [SEL_W-1:0] idx,
   output reg_kind_t        kind,
   output logic [IDX_W-1:0] tab_idx
);
   localparam int TAB_END = IDX_TAB + 2 * N_ENT;

   always_comb begin
      kind        = '0;
      kind.is_id  = (32'(idx) == IDX_ID);
      kind.is_ver = (32'(idx) == IDX_VER);
      kind.is_arb = (32'(idx) == IDX_ARB);
      kind.is_tab = (32'(idx) >= IDX_TAB) && (32'(idx) < TAB_END);
      kind.tab_hi = idx[0];
      tab_idx     = IDX_W'((idx - SEL_W'(IDX_TAB)) >> 1);
   end
endmodule

// File: rtl/irq_redir_entry.sv
module irq_redir_entry
   import irq_regs_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        wr_lo,
   input  logic        wr_hi,
   input  logic [31:0] wdata,
   output logic [31:0] lo_q,
   output logic [31:0] hi_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lo_q <= 32'(1) << MASK_BIT;
         hi_q <= '0;
      end else begin
         if (wr_lo) lo_q <= wdata & LO_KEEP;
         if (wr_hi) hi_q <= wdata & HI_KEEP;
      end
   end
endmodule

// File: rtl/irq_route_regs.sv
module irq_route_regs
   import irq_regs_pkg::*;
#(
   parameter int         N_ENT   = 24,
   parameter int         ADDR_W  = 5,
   parameter int         SEL_W   = 8,
   parameter logic [3:0] ID_INIT = 4'h3,
   parameter logic [7:0] VERSION = 8'h11
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_en,
   input  logic               rd_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [31:0]        wdata,
   output logic [31:0]        rdata,
   output logic               err,
   output logic [N_ENT-1:0]   ent_mask,
   output logic [8*N_ENT-1:0] ent_vector,
   output logic [3*N_ENT-1:0] ent_dmode,
   output logic [N_ENT-1:0]   ent_dstmode,
   output logic [N_ENT-1:0]   ent_pol,
   output logic [N_ENT-1:0]   ent_trig,
   output logic [8*N_ENT-1:0] ent_dest
);
   localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;
   localparam logic [31:0] VER_WORD = (32'(N_ENT - 1) << 16) | 32'(VERSION);

   generate
      if (N_ENT < 1 || N_ENT > 256)
         $error("N_ENT must lie in 1..256");
      if (IDX_TAB + 2 * N_ENT > (1 << SEL_W))
         $error("SEL_W too narrow for the table");
      if (ADDR_W < 5)
         $error("ADDR_W must reach byte offset 16");
      if (SEL_W > 32)
         $error("SEL_W must not exceed 32");
   endgenerate

   logic [SEL_W-1:0] sel_q;
   logic [3:0]       id_q, arb_q;
   reg_kind_t        kind;
   logic [IDX_W-1:0] tab_idx;
   logic [31:0]      lo_arr [N_ENT];
   logic [31:0]      hi_arr [N_ENT];
   logic [31:0]      rd_word;

   wire at_sel  = (32'(addr) == SEL_OFS);
   wire at_win  = (32'(addr) == WIN_OFS);
   wire illegal = (wr_en || rd_en) && !at_sel && !at_win;
   wire win_wr  = wr_en && at_win;

   irq_sel_decode #(.SEL_W(SEL_W), .N_ENT(N_ENT)) dec_i (
      .idx(sel_q), .kind(kind), .tab_idx(tab_idx)
   );

   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      wire hit = win_wr && kind.is_tab && (tab_idx == IDX_W'(i));
      irq_redir_entry ent_i (
         .clk(clk), .rst_n(rst_n),
         .wr_lo(hit && !kind.tab_hi), .wr_hi(hit && kind.tab_hi),
         .wdata(wdata), .lo_q(lo_arr[i]), .hi_q(hi_arr[i])
      );
      assign ent_vector[8*i +: 8]  = lo_arr[i][7:0];
      assign ent_dmode[3*i +: 3]   = lo_arr[i][10:8];
      assign ent_dstmode[i]        = lo_arr[i][11];
      assign ent_pol[i]            = lo_arr[i][13];
      assign ent_trig[i]           = lo_arr[i][15];
      assign ent_mask[i]           = lo_arr[i][MASK_BIT];
      assign ent_dest[8*i +: 8]    = hi_arr[i][31:24];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sel_q <= '0;
         id_q  <= ID_INIT;
         arb_q <= ID_INIT;
      end else if (wr_en && at_sel) begin
         sel_q <= wdata[SEL_W-1:0];
      end else if (win_wr) begin
         if (kind.is_id)  id_q  <= wdata[ID_LSB +: 4];
         if (kind.is_arb) arb_q <= wdata[ID_LSB +: 4];
      end
   end

   always_comb begin
      rd_word = '0;
      if (at_sel)
         rd_word = 32'(sel_q);
      else if (at_win) begin
         if (kind.is_id)       rd_word = 32'(id_q) << ID_LSB;
         else if (kind.is_ver) rd_word = VER_WORD;
         else if (kind.is_arb) rd_word = 32'(arb_q) << ID_LSB;
         else if (kind.is_tab) rd_word = kind.tab_hi ? hi_arr[tab_idx] : lo_arr[tab_idx];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
         err   <= 1'b0;
      end else begin
         err <= illegal;
         if (rd_en) rdata <= rd_word;
      end
   end
endmodule

// File: rtl/irq_route_regs_chk.sv
module irq_route_regs_chk #(
   parameter int N_ENT  = 24,
   parameter int ADDR_W = 5
) (
   input logic               clk,
   input logic               rst_n,
   input logic               wr_en,
   input logic               rd_en,
   input logic [ADDR_W-1:0]  addr,
   input logic [31:0]        rdata,
   input logic               err,
   input logic [N_ENT-1:0]   ent_mask,
   input logic [8*N_ENT-1:0] ent_dest
);
   // R2
   err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      err |-> $past((wr_en || rd_en) && 32'(addr) != 0 && 32'(addr) != 16));
   // R2
   err_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((wr_en || rd_en) && 32'(addr) != 0 && 32'(addr) != 16) |=> err);
   // R3
   rdata_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
   // R7
   mask_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && 32'(addr) == 16) |=> $stable(ent_mask));
   // R7
   dest_write_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(wr_en && 32'(addr) == 16) |=> $stable(ent_dest));
endmodule

bind irq_route_regs irq_route_regs_chk #(.N_ENT(N_ENT), .ADDR_W(ADDR_W)) chk_i (
   .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
   .rdata(rdata), .err(err), .ent_mask(ent_mask), .ent_dest(ent_dest)
);

// File: tb/irq_route_regs_tb.sv
`timescale 1ns/1ps
module irq_route_regs_tb_top;
   localparam int N = 24;
   logic clk = 1'b0, rst_n = 1'b0;
   logic wr_en = 1'b0, rd_en = 1'b0;
   logic [4:0] addr = '0;
   logic [31:0] wdata = '0, rdata;
   logic err;
   logic [N-1:0] ent_mask, ent_dstmode, ent_pol, ent_trig;
   logic [8*N-1:0] ent_vector, ent_dest;
   logic [3*N-1:0] ent_dmode;
   int n_chk = 0, n_fail = 0;

   always #4 clk = ~clk;

   irq_route_regs dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
      .wdata(wdata), .rdata(rdata), .err(err), .ent_mask(ent_mask),
      .ent_vector(ent_vector), .ent_dmode(ent_dmode), .ent_dstmode(ent_dstmode),
      .ent_pol(ent_pol), .ent_trig(ent_trig), .ent_dest(ent_dest)
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic bus_wr(input logic [4:0] a, input logic [31:0] d, output logic e);
      @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
      @(negedge clk); wr_en = 1'b0; e = err;
   endtask

   task automatic bus_rd(input logic [4:0] a, output logic [31:0] d, output logic e);
      @(negedge clk); rd_en = 1'b1; addr = a;
      @(negedge clk); rd_en = 1'b0; d = rdata; e = err;
   endtask

   task automatic reg_wr(input logic [7:0] idx, input logic [31:0] d);
      logic e;
      bus_wr(5'd0, 32'(idx), e);
      bus_wr(5'd16, d, e);
   endtask

   task automatic reg_rd(input logic [7:0] idx, output logic [31:0] d);
      logic e;
      bus_wr(5'd0, 32'(idx), e);
      bus_rd(5'd16, d, e);
   endtask

   task automatic t_reset();
      logic [31:0] d;
      check("R9 mask after reset", 32'(ent_mask), 32'hFF_FFFF);
      check("R9 vectors after reset", 32'(|ent_vector), 32'h0);
      reg_rd(8'h10, d); check("R9 entry0 low", d, 32'h0001_0000);
      reg_rd(8'h3F, d); check("R9 entry23 high", d, 32'h0);
      reg_rd(8'h00, d); check("R4 id reset", d, 32'h0300_0000);
      reg_rd(8'h02, d); check("R6 arb reset", d, 32'h0300_0000);
   endtask

   task automatic t_select();
      logic [31:0] d; logic e;
      bus_wr(5'd0, 32'hABCD_1234, e);
      bus_rd(5'd0, d, e); check("R1 select readback", d, 32'h34);
      check("R1 no err", 32'(e), 32'h0);
   endtask

   task automatic t_id_ver_arb();
      logic [31:0] d;
      reg_wr(8'h00, 32'hFFFF_FFFF);
      reg_rd(8'h00, d); check("R4 id write keeps 27:24", d, 32'h0F00_0000);
      reg_rd(8'h02, d); check("R6 arb independent of id", d, 32'h0300_0000);
      reg_wr(8'h02, 32'h0A00_0000);
      reg_rd(8'h02, d); check("R6 arb write", d, 32'h0A00_0000);
      reg_rd(8'h01, d); check("R5 version", d, 32'h0017_0011);
      reg_wr(8'h01, 32'hFFFF_FFFF);
      reg_rd(8'h01, d); check("R5 version write ignored", d, 32'h0017_0011);
   endtask

   task automatic t_table();
      logic [31:0] d;
      reg_wr(8'h1A, 32'hFFFF_FFFF);
      reg_rd(8'h1A, d); check("R8 low reserved cleared", d, 32'h0001_AFFF);
      check("R7 e5 vector", 32'(ent_vector[40 +: 8]), 32'hFF);
      check("R7 e5 dmode", 32'(ent_dmode[15 +: 3]), 32'h7);
      check("R7 e5 bits", {28'h0, ent_mask[5], ent_dstmode[5], ent_pol[5], ent_trig[5]}, 32'hF);
      reg_wr(8'h1A, 32'h0000_A5C3);
      check("R7 e5 vector2", 32'(ent_vector[40 +: 8]), 32'hC3);
      check("R7 e5 dmode2", 32'(ent_dmode[15 +: 3]), 32'h5);
      check("R7 e5 bits2", {28'h0, ent_mask[5], ent_dstmode[5], ent_pol[5], ent_trig[5]}, 32'h3);
      check("R7 other masks kept", 32'(ent_mask), 32'hFF_FFDF);
      reg_wr(8'h1B, 32'hFFFF_FFFF);
      reg_rd(8'h1B, d); check("R8 high reserved cleared", d, 32'hFF00_0000);
      check("R7 e5 dest", 32'(ent_dest[40 +: 8]), 32'hFF);
      reg_wr(8'h3F, 32'h1234_5678);
      reg_rd(8'h3F, d); check("R7 last entry high", d, 32'h1200_0000);
      check("R7 e23 dest", 32'(ent_dest[184 +: 8]), 32'h12);
   endtask

   task automatic t_undefined();
      logic [31:0] d;
      reg_wr(8'h40, 32'hFFFF_FFFF);
      reg_rd(8'h40, d); check("R10 past-table read zero", d, 32'h0);
      reg_rd(8'h3F, d); check("R10 last entry untouched", d, 32'h1200_0000);
      reg_rd(8'h10, d); check("R10 entry0 untouched", d, 32'h0001_0000);
      reg_wr(8'h03, 32'hFFFF_FFFF);
      reg_rd(8'h03, d); check("R10 index 3 read zero", d, 32'h0);
      reg_rd(8'h00, d); check("R10 id untouched", d, 32'h0F00_0000);
   endtask

   task automatic t_illegal();
      logic [31:0] d; logic e;
      bus_wr(5'd0, 32'h02, e);
      bus_rd(5'd4, d, e);
      check("R2 illegal read err", 32'(e), 32'h1);
      check("R2 illegal read zero", d, 32'h0);
      @(negedge clk); check("R2 err one cycle", 32'(err), 32'h0);
      bus_wr(5'd8, 32'h11, e); check("R2 illegal write err", 32'(e), 32'h1);
      bus_rd(5'd0, d, e); check("R2 select unchanged", d, 32'h02);
      bus_rd(5'd16, d, e); check("R2 arb unchanged", d, 32'h0A00_0000);
      repeat (3) @(negedge clk);
      check("R3 rdata holds", rdata, 32'h0A00_0000);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_select();
      t_id_ver_arb();
      t_table();
      t_undefined();
      t_illegal();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      #200000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule